// File: doc/BRIEF.md
# Board Interrupt Aggregator Register Bank

This block sits on a simple 32-bit register bus and gathers sixteen external interrupt lines from board peripherals into one upstream request for the host interrupt controller. Each source has a bit in an enable mask. When an enabled source changes level, the block writes a one-hot code for that source into a pending word and sets the upstream line to the source's new level. The upstream line therefore follows whichever enabled source changed most recently. A source whose enable bit is clear only updates an internal level vector.

The same bus also holds ten plain 32-bit storage words. Board logic outside this block uses them for LEDs, switches, miscellaneous control and two card slots. When the enable mask is written, the level vector is XORed with the pending word. Every bit that toggles is copied, at its new level, onto a per-bit output vector.

The bus is synchronous. A request with write enable high updates a register at the clock edge. A request with write enable low returns the addressed word on the read data port one cycle later. The offset is 20 bits wide, which covers a 1 MiB window.

Top module: `brd_irq_hub`

## Requirements
- R1: After reset, every register, the level vector, `pin_o`, `irq_o` and `rdata_o` are zero.
- R2: The storage words are at offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88, 0x90, 0xE0 and 0xE4. Each one keeps all 32 written bits. A read returns the stored value on `rdata_o` in the cycle after the read request, and `rdata_o` holds between reads.
- R3: The enable mask (offset 0xC0, bit n enables source n) and the pending word (offset 0xD0) keep only the written bits that are set in 0x000FEEFF. The other bits read back as zero.
- R4: The level vector bit for a source is set when that input rises and cleared when it falls, whatever the enable mask holds.
- R5: When source n changes and mask bit n is set, the pending word becomes exactly bit n, and `irq_o` takes the new level of source n. Both are visible in the cycle after the edge where the change is first sampled.
- R6: A change on a source whose mask bit is clear leaves `irq_o` and the pending word unchanged.
- R7: A write to the enable mask replaces the level vector with itself XOR the pending word, using the values from before the write. For each bit set in that pending word, `pin_o` takes the new level bit. All other `pin_o` bits hold, and `pin_o` changes only on a mask write.
- R8: Reads at any offset outside the twelve defined ones return zero, and writes there change no register. The whole 20-bit offset is compared, so 0x10010 is not the same address as 0x10.
- R9: When several enabled sources change in the same cycle, the lowest-numbered one sets the pending word and `irq_o`.
- R10: When an enabled source changes in the same cycle as a bus write to the pending word, the source's one-hot code wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 20 | Byte offset inside the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_src_i | input | 16 | External interrupt inputs |
| irq_o | output | 1 | Upstream interrupt line |
| pin_o | output | 32 | Per-bit level output vector |

## Verification
Most of the interrupt state reaches the ports within one cycle. A wrong capture shows on `irq_o` in the cycle after the input edge, and a read of the pending word shows it one cycle after that. The level vector has no read port. An error in it shows up only at the next enable-mask write, as a wrong bit on `pin_o`. For that reason the bench writes pending bits and then issues chains of mask writes after input rises and falls that have no other effect. A wrong address decode shows on the first read-back of a neighbouring word.

// File: rtl/brd_irq_pkg.sv
package brd_irq_pkg;
  localparam int unsigned OFS_W   = 20;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned N_SRC   = 16;
  localparam int unsigned N_STORE = 10;
  localparam logic [DATA_W-1:0] LATCH_MASK = 32'h000F_EEFF;
  localparam logic [OFS_W-1:0]  OFS_MASK   = 20'h000C0;
  localparam logic [OFS_W-1:0]  OFS_PEND   = 20'h000D0;

  function automatic logic [OFS_W-1:0] store_ofs(input int unsigned i);
    case (i)
      0:       return 20'h00010;
      1:       return 20'h00014;
      2:       return 20'h00040;
      3:       return 20'h00060;
      4:       return 20'h00080;
      5:       return 20'h00084;
      6:       return 20'h00088;
      7:       return 20'h00090;
      8:       return 20'h000E0;
      default: return 20'h000E4;
    endcase
  endfunction
endpackage

// File: rtl/brd_irq_pick.sv
module brd_irq_pick #(
  parameter int unsigned N  = 16,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign hit_o = |req_i;
endmodule

// File: rtl/brd_irq_core.sv
module brd_irq_core #(
  parameter int unsigned N_SRC  = 16,
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] LATCH = '1,
  localparam int unsigned IW = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mask_wr_i,
  input  logic              pend_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_SRC-1:0]  irq_src_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] pend_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] pin_o
);
  logic [N_SRC-1:0]  src_q, chg, en_chg;
  logic [DATA_W-1:0] lvl_q, lvl_d, pin_d, mask_q, pend_q, pend_d;
  logic              hit_v, irq_d;
  logic [IW-1:0]     hit_idx;

  assign chg    = irq_src_i ^ src_q;
  assign en_chg = chg & mask_q[N_SRC-1:0];

  brd_irq_pick #(.N(N_SRC)) u_pick (
    .req_i (en_chg),
    .hit_o (hit_v),
    .idx_o (hit_idx)
  );

  always_comb begin
    lvl_d = lvl_q;
    pin_d = pin_q_w();
    if (mask_wr_i) begin
      lvl_d = lvl_q ^ pend_q;
      pin_d = (pin_o & ~pend_q) | (lvl_d & pend_q);
    end
    for (int b = 0; b < N_SRC; b++) begin
      if (chg[b]) lvl_d[b] = irq_src_i[b];
    end
  end

  function automatic logic [DATA_W-1:0] pin_q_w();
    return pin_o;
  endfunction

  always_comb begin
    pend_d = pend_q;
    irq_d  = irq_o;
    if (hit_v) begin
      pend_d = DATA_W'(1) << hit_idx;
      irq_d  = irq_src_i[hit_idx];
    end else if (pend_wr_i) begin
      pend_d = wdata_i & LATCH;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      lvl_q  <= '0;
      pin_o  <= '0;
      mask_q <= '0;
      pend_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      src_q  <= irq_src_i;
      lvl_q  <= lvl_d;
      pin_o  <= pin_d;
      pend_q <= pend_d;
      irq_o  <= irq_d;
      if (mask_wr_i) mask_q <= wdata_i & LATCH;
    end
  end

  assign mask_o = mask_q;
  assign pend_o = pend_q;

  AST_IRQ_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_v |=> irq_o == $past(irq_src_i[hit_idx])); // R5
  AST_PEND_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_v |=> $countones(pend_q) == 1); // R5
  AST_PEND_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_v && !pend_wr_i) |=> $stable(pend_q)); // R6
  AST_IRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_v |=> $stable(irq_o)); // R6
  AST_PIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_wr_i |=> $stable(pin_o)); // R7
  AST_PICK_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_v |-> (en_chg & ((N_SRC'(1) << hit_idx) - N_SRC'(1))) == '0); // R9
endmodule

// File: rtl/brd_irq_regfile.sv
module brd_irq_regfile #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned N_STORE = 10
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_i,
  input  logic                           we_i,
  input  logic [brd_irq_pkg::OFS_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic [DATA_W-1:0]              mask_i,
  input  logic [DATA_W-1:0]              pend_i,
  output logic [DATA_W-1:0]              rdata_o
);
  logic [DATA_W-1:0] store_q [N_STORE];
  logic [DATA_W-1:0] rd_val;
  logic              rd_hit;

  for (genvar i = 0; i < N_STORE; i++) begin : g_store
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) store_q[i] <= '0;
      else if (req_i && we_i && addr_i == brd_irq_pkg::store_ofs(i)) store_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rd_val = '0;
    rd_hit = 1'b0;
    for (int i = 0; i < N_STORE; i++) begin
      if (addr_i == brd_irq_pkg::store_ofs(i)) begin
        rd_val = store_q[i];
        rd_hit = 1'b1;
      end
    end
    if (addr_i == brd_irq_pkg::OFS_MASK) begin
      rd_val = mask_i;
      rd_hit = 1'b1;
    end
    if (addr_i == brd_irq_pkg::OFS_PEND) begin
      rd_val = pend_i;
      rd_hit = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_o <= '0;
    else if (req_i && !we_i)  rdata_o <= rd_val;
  end

  AST_UNDEF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !rd_hit) |=> rdata_o == '0); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o)); // R2
endmodule

// File: rtl/brd_irq_hub.sv
module brd_irq_hub #(
  parameter int unsigned N_SRC  = brd_irq_pkg::N_SRC,
  parameter int unsigned DATA_W = brd_irq_pkg::DATA_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_i,
  input  logic                          we_i,
  input  logic [brd_irq_pkg::OFS_W-1:0] addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  input  logic [N_SRC-1:0]              irq_src_i,
  output logic                          irq_o,
  output logic [DATA_W-1:0]             pin_o
);
  logic              mask_wr, pend_wr;
  logic [DATA_W-1:0] mask_w, pend_w;

  assign mask_wr = req_i && we_i && addr_i == brd_irq_pkg::OFS_MASK;
  assign pend_wr = req_i && we_i && addr_i == brd_irq_pkg::OFS_PEND;

  brd_irq_core #(
    .N_SRC  (N_SRC),
    .DATA_W (DATA_W),
    .LATCH  (DATA_W'(brd_irq_pkg::LATCH_MASK))
  ) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mask_wr_i (mask_wr),
    .pend_wr_i (pend_wr),
    .wdata_i   (wdata_i),
    .irq_src_i (irq_src_i),
    .mask_o    (mask_w),
    .pend_o    (pend_w),
    .irq_o     (irq_o),
    .pin_o     (pin_o)
  );

  brd_irq_regfile #(
    .DATA_W  (DATA_W),
    .N_STORE (brd_irq_pkg::N_STORE)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .mask_i  (mask_w),
    .pend_i  (pend_w),
    .rdata_o (rdata_o)
  );
endmodule

// File: tb/tb_brd_irq_hub.sv
module tb_brd_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [19:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] src = '0;
  logic        irq;
  logic [31:0] pin;

  int checks = 0, fails = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  bit          done = 1'b0;

  always #5 clk = ~clk;

  brd_irq_hub dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_src_i(src), .irq_o(irq), .pin_o(pin)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // monitor: pops expected read data one cycle after each read request
  always @(posedge clk) begin
    if (rst_n && req && !we) begin
      @(negedge clk);
      chk(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic wr(input logic [19:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [19:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_src(input logic [15:0] v);
    @(negedge clk);
    src = v;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    src = '0; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    report();
  end

  initial begin
    logic [19:0] ofs [10] = '{20'h10, 20'h14, 20'h40, 20'h60, 20'h80,
                              20'h84, 20'h88, 20'h90, 20'hE0, 20'hE4};
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(rdata, 32'h0, "R1 rdata");
    chk({31'h0, irq}, 32'h0, "R1 irq");
    chk(pin, 32'h0, "R1 pin");
    rd(20'hC0, 32'h0, "R1 mask");
    rd(20'hD0, 32'h0, "R1 pend");
    rd(20'h88, 32'h0, "R1 store");
    // R2 storage words
    for (int i = 0; i < 10; i++) wr(ofs[i], 32'hA5C3_0000 ^ (32'h1357_9BDF * (i + 1)));
    for (int i = 0; i < 10; i++) rd(ofs[i], 32'hA5C3_0000 ^ (32'h1357_9BDF * (i + 1)), "R2 readback");
    chk(rdata, 32'hA5C3_0000 ^ (32'h1357_9BDF * 10), "R2 rdata hold");
    // R3 latch mask
    wr(20'hC0, 32'hFFFF_FFFF);
    rd(20'hC0, 32'h000F_EEFF, "R3 mask");
    wr(20'hD0, 32'hFFFF_FFFF);
    rd(20'hD0, 32'h000F_EEFF, "R3 pend");
    wr(20'hD0, 32'h0);
    wr(20'hC0, 32'h0);
    // R8 undefined offsets
    wr(20'h20, 32'hDEAD_BEEF);
    rd(20'h20, 32'h0, "R8 undef read");
    wr(20'h10010, 32'h1234_5678);
    rd(20'h10010, 32'h0, "R8 alias read");
    rd(20'h10, 32'hA5C3_0000 ^ 32'h1357_9BDF, "R8 no alias write");
    // R6 disabled source
    set_src(16'h0008);
    chk({31'h0, irq}, 32'h0, "R6 irq");
    rd(20'hD0, 32'h0, "R6 pend");
    // R5 enabled source
    wr(20'hC0, 32'h0000_0020);
    set_src(16'h0028);
    chk({31'h0, irq}, 32'h1, "R5 irq rise");
    rd(20'hD0, 32'h0000_0020, "R5 pend");
    set_src(16'h0008);
    chk({31'h0, irq}, 32'h0, "R5 irq fall");
    rd(20'hD0, 32'h0000_0020, "R5 pend after fall");
    // R9 simultaneous changes
    wr(20'hC0, 32'h0000_00FF);
    set_src(16'h004C);
    chk({31'h0, irq}, 32'h1, "R9 irq");
    rd(20'hD0, 32'h0000_0004, "R9 pend lowest");
    // R6 with upstream high
    wr(20'hC0, 32'h0000_0002);
    set_src(16'h0048);
    chk({31'h0, irq}, 32'h1, "R6 irq held");
    rd(20'hD0, 32'h0000_0004, "R6 pend held");
    // R10 capture beats bus write
    @(negedge clk);
    src = 16'h004A; req = 1'b1; we = 1'b1; addr = 20'hD0; wdata = 32'h0000_0800;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    rd(20'hD0, 32'h0000_0002, "R10 pend");
    // R4 / R7 level vector through pin vector
    do_reset();
    chk(pin, 32'h0, "R1 pin after reset");
    set_src(16'h0200);
    wr(20'hD0, 32'h0001_0201);
    chk(pin, 32'h0, "R7 pin hold");
    wr(20'hC0, 32'h0);
    chk(pin, 32'h0001_0001, "R4 rise tracked");
    wr(20'hC0, 32'h0);
    chk(pin, 32'h0000_0200, "R7 second toggle");
    set_src(16'h0000);
    chk(pin, 32'h0000_0200, "R7 pin hold on input");
    wr(20'hC0, 32'h0);
    chk(pin, 32'h0001_0201, "R4 fall tracked");
    repeat (3) @(negedge clk);
    report();
  end
endmodule